// File: doc/BRIEF.md
# Comparator event interrupt controller

This block is the digital side of an external analog comparator. It brings the comparator's raw one-bit result into the clock domain through a short synchronizer. It watches the synchronized level for an edge of a kind that software picks, records a matching edge in a sticky flag, and raises an interrupt request. The comparator result reads as one when the positive input is above the negative input, and as zero otherwise. The same synchronized level can be passed on to a timer as its input-capture trigger.

Software controls the block through one 8-bit control/status register on a small register bus with select, read, write and write-data signals. Two register bits are passed to the analog side as plain outputs. One powers the comparator down. The other swaps the positive input for a fixed internal reference. The interrupt is gated by a global enable that comes from outside. The flag is cleared when the interrupt vector is taken, which an acknowledge pulse signals, or when software writes a one to it.

Top module: `cmp_evt_ctrl`

## Requirements
- R1: After reset every writable register bit is zero. A selected read returns 8'h00 while the comparator input is low, and `irq_o`, `cap_trig_o`, `ref_sel_o` and `cmp_off_o` are all low.
- R2: The status bit (bit 5) shows the raw input after two register stages. A raw level that is present at clock edge n is readable after edge n+1. Bit 5 ignores writes.
- R3: The two-bit mode field (bits 1:0) picks the event that sets the flag (bit 4). 00 is any change of the synchronized level, 01 is no event, 10 is a falling edge and 11 is a rising edge. The flag rises at the edge that follows the change of the synchronized level.
- R4: `irq_o` is high exactly while the flag, the interrupt-enable bit (bit 3) and `gie_i` are all high.
- R5: A `vec_ack_i` pulse clears the flag at the next edge.
- R6: Writing one to bit 4 clears the flag. Writing zero to it leaves the flag unchanged. An event and a clear at the same edge leave the flag set.
- R7: The register is laid out as bit 7 power-down, bit 6 reference select, bit 5 status, bit 4 flag, bit 3 interrupt enable, bit 2 capture enable, bits 1:0 mode. A write updates bits 7, 6, 3, 2, 1 and 0 from the write data.
- R8: `cmp_off_o` follows bit 7 and `ref_sel_o` follows bit 6.
- R9: `cap_trig_o` equals the synchronized level while the capture-enable bit (bit 2) is set, and is zero otherwise.
- R10: While bit 7 is set, the synchronized level is held at zero and the raw input is ignored. Setting or clearing bit 7 can therefore produce an edge that sets the flag.
- R11: `bus_rdata_o` is 8'h00 unless both `bus_sel_i` and `bus_rd_i` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_raw_i | input | 1 | Raw comparator result, asynchronous |
| bus_sel_i | input | 1 | Register select |
| bus_rd_i | input | 1 | Read strobe |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data |
| gie_i | input | 1 | Global interrupt enable |
| vec_ack_i | input | 1 | Interrupt vector taken |
| irq_o | output | 1 | Interrupt request |
| ref_sel_o | output | 1 | Use the internal reference as the positive input |
| cmp_off_o | output | 1 | Power down the comparator |
| cap_trig_o | output | 1 | Timer input-capture trigger |

## Verification
Directed pulses of the raw input are run in the rising, falling, any-change and no-event modes. They separate the edge polarities and pin the two-stage latency to one exact cycle. An event that lands on the same edge as a write-one clear shows which of the two wins. A power-down toggle while the input sits high shows the forced falling edge and, on release, a rising edge. A long random run mixes slow input toggling, random writes, acknowledges and global-enable changes. It is compared every cycle against a reference model in the bench, which catches ordering errors among set, acknowledge and software clear.

// File: rtl/cmp_evt_pkg.sv
package cmp_evt_pkg;
  localparam int CSR_W = 8;

  localparam int B_DIS  = 7;
  localparam int B_REF  = 6;
  localparam int B_OUT  = 5;
  localparam int B_FLAG = 4;
  localparam int B_IE   = 3;
  localparam int B_CAP  = 2;

  typedef enum logic [1:0] {
    MODE_ANY  = 2'b00,
    MODE_OFF  = 2'b01,
    MODE_FALL = 2'b10,
    MODE_RISE = 2'b11
  } evt_mode_e;

  // event decision from the current and previous synchronized level
  function automatic logic edge_hit(evt_mode_e m, logic cur, logic prv);
    logic hit;
    unique case (m)
      MODE_ANY:  hit = cur ^ prv;
      MODE_FALL: hit = prv & ~cur;
      MODE_RISE: hit = cur & ~prv;
      default:   hit = 1'b0;
    endcase
    return hit;
  endfunction
endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_i,
  input  logic raw_i,
  output logic sync_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sh_q <= '0;
    else if (hold_i) sh_q <= '0;
    else             sh_q <= {sh_q[STAGES-2:0], raw_i};
  end

  assign sync_o = sh_q[STAGES-1];
endmodule

// File: rtl/cmp_edge_det.sv
module cmp_edge_det
  import cmp_evt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  evt_mode_e mode_i,
  input  logic      sig_i,
  output logic      evt_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sig_i;
  end

  assign evt_o = edge_hit(mode_i, sig_i, prev_q);
endmodule

// File: rtl/cmp_flag.sv
module cmp_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/cmp_evt_ctrl.sv
module cmp_evt_ctrl
  import cmp_evt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_raw_i,
  input  logic             bus_sel_i,
  input  logic             bus_rd_i,
  input  logic             bus_wr_i,
  input  logic [CSR_W-1:0] bus_wdata_i,
  output logic [CSR_W-1:0] bus_rdata_o,
  input  logic             gie_i,
  input  logic             vec_ack_i,
  output logic             irq_o,
  output logic             ref_sel_o,
  output logic             cmp_off_o,
  output logic             cap_trig_o
);
  logic      dis_q, ref_q, ie_q, cap_q;
  evt_mode_e mode_q;
  logic      wr_hit, rd_hit, flag_clr;
  logic      sync_w, evt_w, flag_w;
  logic      unused_wbit;

  assign wr_hit      = bus_sel_i & bus_wr_i;
  assign rd_hit      = bus_sel_i & bus_rd_i;
  assign unused_wbit = bus_wdata_i[B_OUT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis_q  <= 1'b0;
      ref_q  <= 1'b0;
      ie_q   <= 1'b0;
      cap_q  <= 1'b0;
      mode_q <= MODE_ANY;
    end else if (wr_hit) begin
      dis_q  <= bus_wdata_i[B_DIS];
      ref_q  <= bus_wdata_i[B_REF];
      ie_q   <= bus_wdata_i[B_IE];
      cap_q  <= bus_wdata_i[B_CAP];
      mode_q <= evt_mode_e'(bus_wdata_i[1:0]);
    end
  end

  cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .hold_i(dis_q), .raw_i(cmp_raw_i), .sync_o(sync_w)
  );

  cmp_edge_det u_edge (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_q), .sig_i(sync_w), .evt_o(evt_w)
  );

  assign flag_clr = vec_ack_i | (wr_hit & bus_wdata_i[B_FLAG]);

  cmp_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set_i(evt_w), .clr_i(flag_clr), .flag_o(flag_w)
  );

  assign irq_o      = flag_w & ie_q & gie_i;
  assign ref_sel_o  = ref_q;
  assign cmp_off_o  = dis_q;
  assign cap_trig_o = cap_q & sync_w;
  assign bus_rdata_o = rd_hit ? {dis_q, ref_q, sync_w, flag_w, ie_q, cap_q, mode_q}
                              : '0;
endmodule

// File: rtl/cmp_evt_chk.sv
module cmp_evt_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       irq_i,
  input logic       gie_i,
  input logic       ack_i,
  input logic       cap_trig_i,
  input logic       ie_i,
  input logic       cap_i,
  input logic       dis_i,
  input logic       flag_i,
  input logic       evt_i,
  input logic       sync_i,
  input logic [1:0] mode_i
);
  // R4
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_i |-> (gie_i && ie_i && flag_i));

  // R5
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !evt_i) |=> !flag_i);

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i |=> flag_i);

  // R3
  flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_i) |-> $past(evt_i));

  // R3
  mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b01) |-> !evt_i);

  // R10
  dis_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dis_i |=> !sync_i);

  // R9
  cap_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_i |-> !cap_trig_i);
endmodule

bind cmp_evt_ctrl cmp_evt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq_i(irq_o), .gie_i(gie_i), .ack_i(vec_ack_i),
  .cap_trig_i(cap_trig_o), .ie_i(ie_q), .cap_i(cap_q), .dis_i(dis_q),
  .flag_i(flag_w), .evt_i(evt_w), .sync_i(sync_w), .mode_i(mode_q)
);

// File: tb/tb_cmp_evt_ctrl.sv
`timescale 1ns/1ps
module tb_cmp_evt_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic raw = 0, sel = 0, rd = 0, wr = 0, gie = 0, ack = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic irq, refs, off, cap;
  int checks = 0, errors = 0;
  bit finished = 0;

  // reference model state
  bit m_dis, m_ref, m_ie, m_cap, m_flag, m_s1, m_s2, m_prev;
  bit [1:0] m_mode;

  always #5 clk = ~clk;

  cmp_evt_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cmp_raw_i(raw), .bus_sel_i(sel), .bus_rd_i(rd),
    .bus_wr_i(wr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .gie_i(gie),
    .vec_ack_i(ack), .irq_o(irq), .ref_sel_o(refs), .cmp_off_o(off),
    .cap_trig_o(cap)
  );

  function automatic bit ev(bit [1:0] m, bit c, bit p);
    if (m == 2'b00) return c != p;
    if (m == 2'b11) return c && !p;
    if (m == 2'b10) return p && !c;
    return 1'b0;
  endfunction

  function automatic bit [7:0] pack_csr();
    return {m_dis, m_ref, m_s2, m_flag, m_ie, m_cap, m_mode};
  endfunction

  task automatic chk(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit e, w, nf;
    e  = ev(m_mode, m_s2, m_prev);
    w  = sel && wr;
    nf = e ? 1'b1 : ((ack || (w && wdata[4])) ? 1'b0 : m_flag);
    m_prev = m_s2;
    m_s2   = m_dis ? 1'b0 : m_s1;
    m_s1   = m_dis ? 1'b0 : raw;
    if (w) begin
      m_dis = wdata[7]; m_ref = wdata[6]; m_ie = wdata[3];
      m_cap = wdata[2]; m_mode = wdata[1:0];
    end
    m_flag = nf;
  endtask

  task automatic compare(string tag);
    logic [15:0] act, exp;
    act = {4'h0, irq, cap, refs, off, rdata};
    exp = {4'h0, m_flag && m_ie && gie, m_cap && m_s2, m_ref, m_dis,
           (sel && rd) ? pack_csr() : 8'h00};
    chk(act === exp, tag, act, exp);
  endtask

  task automatic cyc(string tag);
    @(posedge clk); model_step();
    @(negedge clk); compare(tag);
  endtask

  task automatic wr_csr(logic [7:0] d, string tag);
    wr = 1; wdata = d; cyc(tag); wr = 0; wdata = 0;
  endtask

  initial begin
    #1_900_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20251));
    sel = 1; rd = 1;
    repeat (3) @(negedge clk);
    compare("R1");
    chk(rdata === 8'h00 && !irq, "R1", {8'h0, rdata}, 16'h0);
    rst_n = 1;
    cyc("R1");

    // layout and analog-side controls, disable forces status low
    raw = 1;
    wr_csr(8'hFF, "R7");
    chk(rdata === 8'hCF, "R7", {8'h0, rdata}, 16'h00CF);
    chk(refs && off, "R8", {14'h0, refs, off}, 16'h3);
    cyc("R10");
    wr_csr(8'h00, "R8");
    chk(!refs && !off, "R8", {14'h0, refs, off}, 16'h0);
    raw = 0; cyc("R7"); cyc("R7"); cyc("R7");
    wr_csr(8'h10, "R6");

    // latency and rising mode
    gie = 1;
    wr_csr(8'h0B, "R3");
    raw = 1;
    cyc("R2"); chk(rdata[5] === 1'b0, "R2", {15'h0, rdata[5]}, 16'h0);
    cyc("R2"); chk(rdata[5] === 1'b1, "R2", {15'h0, rdata[5]}, 16'h1);
    chk(rdata[4] === 1'b0, "R3", {15'h0, rdata[4]}, 16'h0);
    cyc("R3"); chk(rdata[4] === 1'b1 && irq === 1'b1, "R3", {14'h0, rdata[4], irq}, 16'h3);
    gie = 0; #1;
    chk(irq === 1'b0, "R4", {15'h0, irq}, 16'h0);
    gie = 1;
    ack = 1; cyc("R5"); ack = 0;
    chk(rdata[4] === 1'b0, "R5", {15'h0, rdata[4]}, 16'h0);

    // falling edge in rise mode: no event
    raw = 0; repeat (4) cyc("R3");
    chk(rdata[4] === 1'b0, "R3", {15'h0, rdata[4]}, 16'h0);
    // reserved mode 01: no event either way
    wr_csr(8'h09, "R3");
    raw = 1; repeat (4) cyc("R3");
    raw = 0; repeat (4) cyc("R3");
    chk(rdata[4] === 1'b0, "R3", {15'h0, rdata[4]}, 16'h0);
    // falling mode
    wr_csr(8'h0A, "R3");
    raw = 1; repeat (4) cyc("R3");
    chk(rdata[4] === 1'b0, "R3", {15'h0, rdata[4]}, 16'h0);
    raw = 0; repeat (3) cyc("R3");
    chk(rdata[4] === 1'b1, "R3", {15'h0, rdata[4]}, 16'h1);

    // write zero keeps flag, write one clears, set beats clear
    wr_csr(8'h08, "R6");
    chk(rdata[4] === 1'b1, "R6", {15'h0, rdata[4]}, 16'h1);
    wr_csr(8'h18, "R6");
    chk(rdata[4] === 1'b0, "R6", {15'h0, rdata[4]}, 16'h0);
    raw = 1; cyc("R6"); cyc("R6");
    wr_csr(8'h18, "R6");
    chk(rdata[4] === 1'b1, "R6", {15'h0, rdata[4]}, 16'h1);
    wr_csr(8'h18, "R6");

    // capture trigger
    wr_csr(8'h04, "R9");
    chk(cap === 1'b1, "R9", {15'h0, cap}, 16'h1);
    raw = 0; cyc("R9"); cyc("R9");
    chk(cap === 1'b0, "R9", {15'h0, cap}, 16'h0);
    raw = 1; cyc("R9"); cyc("R9");
    wr_csr(8'h00, "R9");
    chk(cap === 1'b0, "R9", {15'h0, cap}, 16'h0);

    // power-down toggle produces an edge while interrupt enabled
    wr_csr(8'h18, "R10");
    wr_csr(8'h88, "R10");
    raw = 0; cyc("R10"); raw = 1; cyc("R10"); cyc("R10");
    chk(irq === 1'b1 && rdata[5] === 1'b0, "R10", {14'h0, irq, rdata[5]}, 16'h2);
    wr_csr(8'h98, "R10");
    chk(rdata[4] === 1'b0, "R10", {15'h0, rdata[4]}, 16'h0);
    wr_csr(8'h08, "R10");
    repeat (3) cyc("R10");
    chk(irq === 1'b1 && rdata[5] === 1'b1, "R10", {14'h0, irq, rdata[5]}, 16'h3);

    // read gating
    rd = 0; cyc("R11");
    chk(rdata === 8'h00, "R11", {8'h0, rdata}, 16'h0);
    rd = 1; sel = 0; cyc("R11");
    chk(rdata === 8'h00, "R11", {8'h0, rdata}, 16'h0);
    sel = 1;

    // random phase
    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 4 == 0) raw = ~raw;
      ack = ($urandom % 10 == 0);
      gie = ($urandom % 8 != 0);
      rd  = ($urandom % 4 != 0);
      sel = ($urandom % 8 != 0);
      wr  = ($urandom % 12 == 0);
      wdata = $urandom;
      if ($urandom % 5 != 0) wdata[7] = 1'b0;
      cyc("R3");
    end
    wr = 0; ack = 0;

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule